// File: doc/BRIEF.md
# Pointer Load-Use Interlock

This block is the hazard detector and stall controller for address-forming pointer reads in a ten-stage in-order pipeline: three fetch stages, decode (ID), address calculation (AC), three memory stages (M0, M1, M2), execute (EX) and writeback (WB). Effective addresses are computed in AC, ahead of the memory stages. A load whose destination is a pointer register only has its data at M2. An instruction in ID that uses that pointer to form an address is therefore held in ID until the data can be forwarded into AC. A back-to-back pointer load and dependent access costs three dead cycles, and software does not have to pad the sequence.

The block keeps its own record of what sits in AC through WB: a valid bit, a pointer-load flag and the destination pointer index. It compares the ID instruction's address source with that record. While a hazard exists it raises `stall_o`, which holds the fetch stages and ID, and `bubble_o`, which puts an empty slot into AC. Everything from AC onward keeps moving. When the ID instruction advances, `fwd_sel_o` names the stage that supplies the pointer value.

Top module: `ptr_interlock`

## Requirements
- R1: A pointer load directly followed by an instruction that uses its destination as an address source gives exactly three stall cycles. `stall_o` is never high for more than three cycles in a row.
- R2: `stall_o` is high, in the same cycle, whenever a valid ID instruction with `id_src_use_i`=1 has `id_src_idx_i` equal to the destination of a valid pointer load that is in AC, M0 or M1.
- R3: On every stall cycle `bubble_o` is 1, and after the next clock edge `ac_valid_o` is 0, because an empty slot was placed into AC.
- R4: If one, two, or three or more independent instructions sit between the pointer load and its user, the stall count is two, one and zero respectively.
- R5: No stall occurs when `id_src_use_i`=0, when the source index matches no in-flight pointer load, or when `id_valid_i`=0. A cycle with `id_valid_i`=0 puts nothing into the pipeline, even with `id_ld_ptr_i`=1.
- R6: While a valid ID instruction with `id_src_use_i`=1 is not stalled, `fwd_sel_o` is 1 if the matching load is in M2, 2 if it is in EX, 3 if it is in WB, and 0 if there is no matching load in AC through WB. `fwd_sel_o` is 0 in every stall cycle.
- R7: When several in-flight pointer loads target the same register, the youngest one (nearest to AC) decides both the stall and `fwd_sel_o`.
- R8: With `flush_i`=1, `stall_o` is 0 in the same cycle. After the next edge every tracked stage is invalid (`ac_valid_o`=0), and a flushed load causes no later stall.
- R9: After reset `stall_o`, `bubble_o`, `ac_valid_o` and `fwd_sel_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Pipeline flush; invalidates AC..WB |
| id_valid_i | input | 1 | ID holds a valid instruction |
| id_src_use_i | input | 1 | ID instruction reads a pointer to form an address |
| id_src_idx_i | input | 3 | Pointer register read by the ID instruction |
| id_ld_ptr_i | input | 1 | ID instruction is a load into a pointer register |
| id_dst_idx_i | input | 3 | Pointer register written by the ID load |
| stall_o | output | 1 | Hold the fetch stages and ID |
| bubble_o | output | 1 | Put an empty slot into AC |
| fwd_sel_o | output | 2 | Pointer source: 0 register file, 1 M2, 2 EX, 3 WB |
| ac_valid_o | output | 1 | AC holds a valid instruction |

## Verification
`stall_o`, `bubble_o` and `fwd_sel_o` are combinational from the ID inputs and the tracked stages, so they are due in the same cycle as the stimulus. `ac_valid_o` changes one edge after the stimulus, and a flush clears the tracked stages one edge after `flush_i` is applied. The bench drives its inputs on the falling edge and reads the combinational outputs 2 ns later, before the next rising edge. It reads `ac_valid_o` only at the falling edge that follows the capturing edge. It counts stall cycles until the ID instruction advances and compares that count with the gap-derived value max(0, 3 − gap). This is done for every gap from 0 to 7 and every pair of destination and source indices.

// File: rtl/ptr_ilk_pkg.sv
package ptr_ilk_pkg;
  // pointer source select for the AC stage
  typedef enum logic [1:0] {
    FWD_RF = 2'd0,
    FWD_M2 = 2'd1,
    FWD_EX = 2'd2,
    FWD_WB = 2'd3
  } fwd_sel_e;

  // stages past the hazard window that can forward (M2, EX, WB)
  localparam int unsigned FWD_STAGES = 3;
endpackage

// File: rtl/ptr_ilk_track.sv
module ptr_ilk_track #(
  parameter int unsigned PTR_W   = 3,
  parameter int unsigned N_STAGE = 6
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              flush_i,
  input  logic                              ins_vld_i,
  input  logic                              ins_ld_i,
  input  logic [PTR_W-1:0]                  ins_dst_i,
  output logic [N_STAGE-1:0]                vld_o,
  output logic [N_STAGE-1:0]                ld_o,
  output logic [N_STAGE-1:0][PTR_W-1:0]     dst_o
);

  logic [N_STAGE-1:0]            vld_q, ld_q;
  logic [N_STAGE-1:0][PTR_W-1:0] dst_q;

  // stage 0 = AC, last = WB
  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    logic             vld_in, ld_in;
    logic [PTR_W-1:0] dst_in;

    if (s == 0) begin : g_head
      assign vld_in = ins_vld_i;
      assign ld_in  = ins_vld_i & ins_ld_i;
      assign dst_in = ins_dst_i;
    end else begin : g_body
      assign vld_in = vld_q[s-1];
      assign ld_in  = ld_q[s-1];
      assign dst_in = dst_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        ld_q[s]  <= 1'b0;
        dst_q[s] <= '0;
      end else if (flush_i) begin
        vld_q[s] <= 1'b0;
        ld_q[s]  <= 1'b0;
      end else begin
        vld_q[s] <= vld_in;
        ld_q[s]  <= ld_in;
        dst_q[s] <= dst_in;
      end
    end
  end

  assign vld_o = vld_q;
  assign ld_o  = ld_q;
  assign dst_o = dst_q;

endmodule

// File: rtl/ptr_ilk_match.sv
module ptr_ilk_match #(
  parameter int unsigned PTR_W   = 3,
  parameter int unsigned N_STAGE = 6
) (
  input  logic [N_STAGE-1:0]            vld_i,
  input  logic [N_STAGE-1:0]            ld_i,
  input  logic [N_STAGE-1:0][PTR_W-1:0] dst_i,
  input  logic [PTR_W-1:0]              src_i,
  output logic [N_STAGE-1:0]            hit_o
);

  for (genvar s = 0; s < N_STAGE; s++) begin : g_cmp
    assign hit_o[s] = vld_i[s] & ld_i[s] & (dst_i[s] == src_i);
  end

endmodule

// File: rtl/ptr_ilk_prio.sv
module ptr_ilk_prio
  import ptr_ilk_pkg::*;
#(
  parameter int unsigned STALL_STAGES = 3,
  parameter int unsigned N_STAGE      = STALL_STAGES + FWD_STAGES
) (
  input  logic [N_STAGE-1:0] hit_i,
  output logic               haz_o,
  output fwd_sel_e           fwd_o
);

  // youngest (lowest index) hit wins
  always_comb begin
    logic found;
    found = 1'b0;
    haz_o = 1'b0;
    fwd_o = FWD_RF;
    for (int k = 0; k < N_STAGE; k++) begin
      if (!found && hit_i[k]) begin
        found = 1'b1;
        if (k < STALL_STAGES) haz_o = 1'b1;
        else                  fwd_o = fwd_sel_e'(2'(k - STALL_STAGES + 1));
      end
    end
  end

endmodule

// File: rtl/ptr_interlock.sv
module ptr_interlock
  import ptr_ilk_pkg::*;
#(
  parameter int unsigned PTR_W        = 3,
  parameter int unsigned STALL_STAGES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             id_valid_i,
  input  logic             id_src_use_i,
  input  logic [PTR_W-1:0] id_src_idx_i,
  input  logic             id_ld_ptr_i,
  input  logic [PTR_W-1:0] id_dst_idx_i,
  output logic             stall_o,
  output logic             bubble_o,
  output logic [1:0]       fwd_sel_o,
  output logic             ac_valid_o
);

  localparam int unsigned N_STAGE = STALL_STAGES + FWD_STAGES;

  logic [N_STAGE-1:0]            vld, ld, hit;
  logic [N_STAGE-1:0][PTR_W-1:0] dst;
  logic                          haz, use_ptr, stall, advance;
  fwd_sel_e                      fwd;

  assign use_ptr = id_valid_i & id_src_use_i & ~flush_i;
  assign stall   = use_ptr & haz;
  assign advance = id_valid_i & ~stall;

  ptr_ilk_track #(.PTR_W(PTR_W), .N_STAGE(N_STAGE)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .ins_vld_i (advance),
    .ins_ld_i  (id_ld_ptr_i),
    .ins_dst_i (id_dst_idx_i),
    .vld_o     (vld),
    .ld_o      (ld),
    .dst_o     (dst)
  );

  ptr_ilk_match #(.PTR_W(PTR_W), .N_STAGE(N_STAGE)) u_match (
    .vld_i (vld),
    .ld_i  (ld),
    .dst_i (dst),
    .src_i (id_src_idx_i),
    .hit_o (hit)
  );

  ptr_ilk_prio #(.STALL_STAGES(STALL_STAGES), .N_STAGE(N_STAGE)) u_prio (
    .hit_i (hit),
    .haz_o (haz),
    .fwd_o (fwd)
  );

  assign stall_o    = stall;
  assign bubble_o   = stall;
  assign fwd_sel_o  = (use_ptr && !haz) ? fwd : FWD_RF;
  assign ac_valid_o = vld[0];

endmodule

// File: rtl/ptr_interlock_chk.sv
module ptr_interlock_chk #(
  parameter int unsigned PTR_W        = 3,
  parameter int unsigned STALL_STAGES = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             id_valid_i,
  input logic             id_src_use_i,
  input logic [PTR_W-1:0] id_src_idx_i,
  input logic             id_ld_ptr_i,
  input logic [PTR_W-1:0] id_dst_idx_i,
  input logic             stall_o,
  input logic             bubble_o,
  input logic [1:0]       fwd_sel_o,
  input logic             ac_valid_o
);

  logic [7:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= '0;
    else if (!stall_o)           run_q <= '0;
    else if (run_q != 8'hff)     run_q <= run_q + 8'd1;
  end

  a_r1_stall_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (32'(run_q) < STALL_STAGES));

  a_r2_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(id_valid_i && id_ld_ptr_i && !stall_o && !flush_i) &&
     id_valid_i && id_src_use_i && !flush_i &&
     id_src_idx_i == $past(id_dst_idx_i)) |-> stall_o);

  a_r3_bubble_in_ac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !ac_valid_o);

  a_r3_bubble_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> bubble_o);

  a_r5_needs_ptr_use: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (id_valid_i && id_src_use_i));

  a_r5_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && !stall_o && !flush_i) |=> ac_valid_o);

  a_r6_no_fwd_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (fwd_sel_o == 2'd0));

  a_r8_flush_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !stall_o);

  a_r8_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !ac_valid_o);

endmodule

bind ptr_interlock ptr_interlock_chk #(
  .PTR_W(PTR_W), .STALL_STAGES(STALL_STAGES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .id_valid_i   (id_valid_i),
  .id_src_use_i (id_src_use_i),
  .id_src_idx_i (id_src_idx_i),
  .id_ld_ptr_i  (id_ld_ptr_i),
  .id_dst_idx_i (id_dst_idx_i),
  .stall_o      (stall_o),
  .bubble_o     (bubble_o),
  .fwd_sel_o    (fwd_sel_o),
  .ac_valid_o   (ac_valid_o)
);

// File: tb/ptr_interlock_tb.sv
`timescale 1ns/1ps
module ptr_interlock_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       flush_i = 1'b0;
  logic       id_valid_i = 1'b0;
  logic       id_src_use_i = 1'b0;
  logic [2:0] id_src_idx_i = '0;
  logic       id_ld_ptr_i = 1'b0;
  logic [2:0] id_dst_idx_i = '0;
  logic       stall_o, bubble_o, ac_valid_o;
  logic [1:0] fwd_sel_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  ptr_interlock u_dut (
    .clk_i, .rst_ni, .flush_i, .id_valid_i, .id_src_use_i, .id_src_idx_i,
    .id_ld_ptr_i, .id_dst_idx_i, .stall_o, .bubble_o, .fwd_sel_o, .ac_valid_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    id_valid_i = 1'b0; id_src_use_i = 1'b0; id_ld_ptr_i = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // called at a falling edge; returns after the instruction left ID
  task automatic issue(input bit use_p, input int src, input bit ld, input int dst,
                       output int nstall, output int fsel);
    id_valid_i   = 1'b1;
    id_src_use_i = use_p;
    id_src_idx_i = 3'(src);
    id_ld_ptr_i  = ld;
    id_dst_idx_i = 3'(dst);
    nstall = 0;
    fsel   = 0;
    forever begin
      #2;
      if (stall_o && nstall < 16) begin
        chk("R3 bubble_o", int'(bubble_o), 1);
        chk("R6 fwd in stall", int'(fwd_sel_o), 0);
        nstall++;
        @(negedge clk_i);
        chk("R3 ac_valid after stall", int'(ac_valid_o), 0);
      end else begin
        fsel = int'(fwd_sel_o);
        @(negedge clk_i);
        break;
      end
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int ns, fs, exp_ns, exp_fs;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #2;
    chk("R9 stall", int'(stall_o), 0);
    chk("R9 bubble", int'(bubble_o), 0);
    chk("R9 ac_valid", int'(ac_valid_o), 0);
    chk("R9 fwd", int'(fwd_sel_o), 0);
    @(negedge clk_i);

    // sweep: gap x destination x source
    for (int g = 0; g < 8; g++) begin
      for (int d = 0; d < 8; d++) begin
        for (int s = 0; s < 8; s++) begin
          issue(1'b0, 0, 1'b1, d, ns, fs);
          for (int k = 0; k < g; k++) issue(1'b0, 0, 1'b0, 0, ns, fs);
          issue(1'b1, s, 1'b0, 0, ns, fs);
          if (s == d) begin
            exp_ns = (g < 3) ? 3 - g : 0;
            exp_fs = (g <= 3) ? 1 : (g == 4) ? 2 : (g == 5) ? 3 : 0;
          end else begin
            exp_ns = 0;
            exp_fs = 0;
          end
          if (s != d)      chk("R5 no match stalls", ns, exp_ns);
          else if (g == 0) chk("R1 back-to-back stalls", ns, exp_ns);
          else             chk("R4 gap stalls", ns, exp_ns);
          chk("R6 fwd select", fs, exp_fs);
          idle(8);
        end
      end
    end

    // R2: load in AC with an unrelated load ahead
    issue(1'b0, 0, 1'b1, 5, ns, fs);
    issue(1'b0, 0, 1'b1, 6, ns, fs);
    issue(1'b1, 5, 1'b0, 0, ns, fs);
    chk("R2 match in M0 stalls", ns, 2);
    idle(8);

    // R5: matching index but no pointer use
    issue(1'b0, 0, 1'b1, 4, ns, fs);
    issue(1'b0, 4, 1'b0, 0, ns, fs);
    chk("R5 no pointer use", ns, 0);
    idle(8);

    // R5: invalid ID slot with load flag enters nothing
    id_valid_i = 1'b0; id_ld_ptr_i = 1'b1; id_dst_idx_i = 3'd4;
    @(negedge clk_i);
    issue(1'b1, 4, 1'b0, 0, ns, fs);
    chk("R5 invalid load ignored", ns, 0);
    chk("R5 invalid load fwd", fs, 0);
    idle(8);

    // R7: two loads to one pointer, back to back
    issue(1'b0, 0, 1'b1, 2, ns, fs);
    issue(1'b0, 0, 1'b1, 2, ns, fs);
    issue(1'b1, 2, 1'b0, 0, ns, fs);
    chk("R7 youngest stall", ns, 3);
    chk("R7 youngest fwd", fs, 1);
    idle(8);

    // R7: youngest at M2 while older at EX
    issue(1'b0, 0, 1'b1, 2, ns, fs);
    issue(1'b0, 0, 1'b1, 2, ns, fs);
    for (int k = 0; k < 3; k++) issue(1'b0, 0, 1'b0, 0, ns, fs);
    issue(1'b1, 2, 1'b0, 0, ns, fs);
    chk("R7 youngest no stall", ns, 0);
    chk("R7 youngest fwd M2", fs, 1);
    idle(8);

    // R8: flush during a stall
    issue(1'b0, 0, 1'b1, 1, ns, fs);
    id_valid_i = 1'b1; id_src_use_i = 1'b1; id_src_idx_i = 3'd1; id_ld_ptr_i = 1'b0;
    #2;
    chk("R2 stall before flush", int'(stall_o), 1);
    flush_i = 1'b1;
    #1;
    chk("R8 flush drops stall", int'(stall_o), 0);
    @(negedge clk_i);
    flush_i = 1'b0;
    #2;
    chk("R8 ac cleared", int'(ac_valid_o), 0);
    chk("R8 no stall after flush", int'(stall_o), 0);
    chk("R8 fwd after flush", int'(fwd_sel_o), 0);
    @(negedge clk_i);
    idle(4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule